// File: doc/BRIEF.md
# Receive FIFO with Paced Host DMA Requests

This block sits between the receive side of an audio serial port and a host or DMA controller. It buffers 32-bit words. When it is enabled, each receive request from the serial port makes it pull a fixed-size burst of words from the port. The burst starts only once the buffer has room for every word of that burst. Toward the host, the block raises a DMA request once the buffer holds a programmed number of words, the event size. After the host acknowledges, the block raises no new request until the host has read that many words. It then checks the fill level again.

When the block is disabled, it is transparent. The serial-port request is passed to the host request output, and host reads go straight to the serial port's word output. The serial port's behaviour does not depend on the mode. Any requests that arrive while a burst is waiting or running are counted in a pending counter and served one after another.

The intake machine has three states:
- `IN_IDLE`: moves to `IN_WAIT` when the pending counter is non-zero.
- `IN_WAIT`: moves to `IN_XFER` when the buffer has room for the whole burst, and consumes one pending request.
- `IN_XFER`: pulls one word per cycle. After the last beat it moves to `IN_WAIT` if requests are still pending, and to `IN_IDLE` otherwise.

The pacing machine has three states:
- `PC_CHECK`: moves to `PC_ASSERT` when the fill level is at least the event size and the event size is non-zero.
- `PC_ASSERT`: holds the request high and moves to `PC_DRAIN` on acknowledge.
- `PC_DRAIN`: moves back to `PC_CHECK` once the event size has been read. Reads made while in `PC_ASSERT` count toward this.

Clearing the enable input flushes the buffer and returns both machines to their idle states.

Top module: `rx_fifo_pacer`

## Requirements
- R1: With `fifo_en` low, `host_dma_req` equals `sp_req`, `sp_rd` equals `host_rd`, and `host_data` equals `sp_data`, all in the same cycle.
- R2: With `fifo_en` high, a burst of `burst_words` pulls starts only when the fill level plus `burst_words` is at most DEPTH. Otherwise the burst waits until reads make room.
- R3: The buffer is never written while it holds DEPTH words.
- R4: Host reads return words in the order the serial port delivered them.
- R5: `host_dma_req` rises when the fill level reaches at least `evt_words`. It stays high until `dma_ack`.
- R6: After an acknowledge, no new request is raised until `evt_words` words have been read. At that point the fill level is checked again, and a new request follows if it still meets the event size.
- R7: The host may read with fewer than `evt_words` words stored, and gets valid data. A read of an empty buffer returns zero and pulses `host_underflow` in that cycle.
- R8: Serial-port requests that arrive while a burst is pending or in progress are each served in turn, up to a pending count of 2^PEND_W-1.
- R9: After reset, `host_dma_req`, `sp_rd` and `host_underflow` are low and the buffer is empty.
- R10: Each serviced request produces exactly `burst_words` pulses of `sp_rd`. Each pulse stores the `sp_data` present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = buffered mode, 0 = pass-through (flushes the buffer) |
| evt_words | input | CW | Words needed before a host request (event size) |
| burst_words | input | CW | Words pulled per serial-port request |
| sp_req | input | 1 | Receive request pulse from the serial port |
| sp_rd | output | 1 | Word read strobe to the serial port |
| sp_data | input | DW | Word offered by the serial port |
| host_rd | input | 1 | Host read strobe |
| host_data | output | DW | Word returned to the host in the read cycle |
| host_underflow | output | 1 | Host read of an empty buffer in this cycle |
| host_dma_req | output | 1 | Receive DMA request to the host |
| dma_ack | input | 1 | Host acknowledge of the DMA request |

## Verification
The checks assume that `burst_words` and `evt_words` are non-zero and do not change while `fifo_en` is high. They also assume that `evt_words` is a multiple of `burst_words`, with at most DEPTH words requested before the host drains the buffer. The stimulus changes these fields only while the block is disabled. Every configuration it uses keeps the event size a whole multiple of the burst size. Requests arrive as single-cycle pulses, and the host acknowledges only while a request is high.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
    typedef enum logic [1:0] {
        IN_IDLE,
        IN_WAIT,
        IN_XFER
    } intake_st_t;

    typedef enum logic [1:0] {
        PC_CHECK,
        PC_ASSERT,
        PC_DRAIN
    } pacer_st_t;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] fill
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            fill <= fill + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign rd_data = mem[rp];
endmodule

// File: rtl/rx_intake_fsm.sv
module rx_intake_fsm
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int PEND_W = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sp_req,
    input  logic [CW-1:0] burst_words,
    input  logic [CW-1:0] fill,
    output logic          pull
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    intake_st_t        state, state_nx;
    logic [PEND_W-1:0] pend;
    logic [CW-1:0]     beat;
    logic              has_room, start, last_beat;

    assign has_room  = ({1'b0, fill} + {1'b0, burst_words}) <= (CW+1)'(DEPTH);
    assign last_beat = (beat == burst_words - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= IN_IDLE;
            pend  <= '0;
            beat  <= '0;
        end else begin
            state <= state_nx;
            if (sp_req && !start && pend != PEND_MAX) pend <= pend + 1'b1;
            else if (start && !sp_req)                pend <= pend - 1'b1;
            beat <= (state == IN_XFER && !last_beat) ? beat + 1'b1 : '0;
        end
    end

    always_comb begin
        state_nx = state;
        start    = 1'b0;
        pull     = 1'b0;
        unique case (state)
            IN_IDLE: if (pend != '0) state_nx = IN_WAIT;
            IN_WAIT: if (has_room) begin
                start    = 1'b1;
                state_nx = IN_XFER;
            end
            IN_XFER: begin
                pull = 1'b1;
                if (last_beat) state_nx = (pend != '0) ? IN_WAIT : IN_IDLE;
            end
            default: state_nx = IN_IDLE;
        endcase
    end
endmodule

// File: rtl/rx_event_pacer.sv
module rx_event_pacer
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] evt_words,
    input  logic [CW-1:0] fill,
    input  logic          popped,
    input  logic          dma_ack,
    output logic          dma_req
);
    pacer_st_t     state, state_nx;
    logic [CW-1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state  <= PC_CHECK;
            rd_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == PC_CHECK)  rd_cnt <= '0;
            else if (popped)        rd_cnt <= rd_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        dma_req  = 1'b0;
        unique case (state)
            PC_CHECK:  if (evt_words != '0 && fill >= evt_words) state_nx = PC_ASSERT;
            PC_ASSERT: begin
                dma_req = 1'b1;
                if (dma_ack) state_nx = PC_DRAIN;
            end
            PC_DRAIN:  if (rd_cnt >= evt_words) state_nx = PC_CHECK;
            default:   state_nx = PC_CHECK;
        endcase
    end
endmodule

// File: rtl/rx_fifo_pacer.sv
module rx_fifo_pacer #(
    parameter int DW     = 32,
    parameter int DEPTH  = 64,
    parameter int PEND_W = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [CW-1:0] evt_words,
    input  logic [CW-1:0] burst_words,
    input  logic          sp_req,
    output logic          sp_rd,
    input  logic [DW-1:0] sp_data,
    input  logic          host_rd,
    output logic [DW-1:0] host_data,
    output logic          host_underflow,
    output logic          host_dma_req,
    input  logic          dma_ack
);
    logic          pull, popped, pace_req, empty;
    logic [CW-1:0] fill;
    logic [DW-1:0] rd_data;

    assign empty  = (fill == '0);
    assign popped = fifo_en && host_rd && !empty;

    rx_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (!fifo_en),
        .wr_en  (pull),
        .wr_data(sp_data),
        .rd_en  (popped),
        .rd_data(rd_data),
        .fill   (fill)
    );

    rx_intake_fsm #(.DEPTH(DEPTH), .PEND_W(PEND_W)) u_intake (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (fifo_en),
        .sp_req     (sp_req),
        .burst_words(burst_words),
        .fill       (fill),
        .pull       (pull)
    );

    rx_event_pacer #(.DEPTH(DEPTH)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (fifo_en),
        .evt_words(evt_words),
        .fill     (fill),
        .popped   (popped),
        .dma_ack  (dma_ack),
        .dma_req  (pace_req)
    );

    always_comb begin
        if (fifo_en) begin
            sp_rd          = pull;
            host_dma_req   = pace_req;
            host_data      = empty ? '0 : rd_data;
            host_underflow = host_rd && empty;
        end else begin
            sp_rd          = host_rd;
            host_dma_req   = sp_req;
            host_data      = sp_data;
            host_underflow = 1'b0;
        end
    end
endmodule

// File: rtl/rx_fifo_checker.sv
module rx_fifo_checker #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic [CW-1:0] burst_words,
    input logic          sp_req,
    input logic          sp_rd,
    input logic          host_rd,
    input logic          host_dma_req,
    input logic          dma_ack,
    input logic          host_underflow,
    input logic [DW-1:0] host_data,
    input logic [CW-1:0] fill
);
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (host_dma_req == sp_req && sp_rd == host_rd));

    assert_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $rose(sp_rd)) |-> ({1'b0, fill} + {1'b0, burst_words} <= (CW+1)'(DEPTH)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && sp_rd) |-> (fill != CW'(DEPTH)));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && host_dma_req && !dma_ack) |=> (host_dma_req || !fifo_en));

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && host_dma_req && dma_ack) |=> !host_dma_req);

    assert_underflow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_underflow |-> (host_data == '0 && host_rd && fill == '0));
endmodule

bind rx_fifo_pacer rx_fifo_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_en       (fifo_en),
    .burst_words   (burst_words),
    .sp_req        (sp_req),
    .sp_rd         (sp_rd),
    .host_rd       (host_rd),
    .host_dma_req  (host_dma_req),
    .dma_ack       (dma_ack),
    .host_underflow(host_underflow),
    .host_data     (host_data),
    .fill          (fill)
);

// File: tb/sim_rx_fifo_pacer.sv
module sim_rx_fifo_pacer;
    localparam int DW = 32;
    localparam int DEPTH = 64;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int NVEC = 5;
    // {burst, event, requests, expected host request}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd4, 8'd8,  8'd1, 8'd0},
        {8'd4, 8'd8,  8'd2, 8'd1},
        {8'd2, 8'd2,  8'd1, 8'd1},
        {8'd8, 8'd16, 8'd3, 8'd1},
        {8'd1, 8'd4,  8'd3, 8'd0}
    };

    logic clk = 0, rst_n = 0, fifo_en = 0, sp_req = 0, host_rd = 0, dma_ack = 0;
    logic [CW-1:0] evt_words = 0, burst_words = 0;
    logic sp_rd, host_underflow, host_dma_req;
    logic [DW-1:0] sp_data, host_data;
    int src_idx = 0, pulls = 0, checks = 0, fails = 0;

    always #5 clk = ~clk;

    assign sp_data = 32'hA000_0000 + src_idx;
    always @(posedge clk) begin
        if (sp_rd) src_idx <= src_idx + 1;
        if (sp_rd && fifo_en) pulls <= pulls + 1;
    end

    rx_fifo_pacer #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sp_req = 1;
            @(negedge clk); sp_req = 0;
        end
    endtask

    task automatic ack();
        @(negedge clk); dma_ack = 1;
        @(negedge clk); dma_ack = 0;
    endtask

    task automatic host_read(output logic [DW-1:0] d, output logic uf);
        @(negedge clk); host_rd = 1;
        #2; d = host_data; uf = host_underflow;
        @(negedge clk); host_rd = 0;
    endtask

    task automatic configure(input int b, input int e);
        @(negedge clk); fifo_en = 0;
        @(negedge clk); burst_words = CW'(b); evt_words = CW'(e);
        @(negedge clk); fifo_en = 1;
    endtask

    task automatic read_seq(input int n, input int base, input string req);
        logic [DW-1:0] d; logic uf;
        for (int k = 0; k < n; k++) begin
            host_read(d, uf);
            check(req, d, 32'hA000_0000 + base + k);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] d; logic uf;
        int base, p0;
        wait_cyc(3); rst_n = 1; wait_cyc(1);
        // R9 reset state
        check("R9 req", host_dma_req, 0);
        check("R9 sp_rd", sp_rd, 0);
        check("R9 underflow", host_underflow, 0);

        // Table walk: R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NVEC; v++) begin
            int b = VEC[v][31:24], e = VEC[v][23:16], n = VEC[v][15:8], x = VEC[v][7:0];
            configure(b, e);
            base = src_idx; p0 = pulls;
            pulse_req(n);
            wait_cyc(80);
            check("R8 R10 pulls", pulls - p0, n * b);
            check("R5 req level", host_dma_req, x);
            if (x != 0) begin
                ack(); wait_cyc(3);
                check("R6 req low after ack", host_dma_req, 0);
            end
            read_seq(n * b, base, "R4 R7 order");
            wait_cyc(5);
            check("R6 no req when empty", host_dma_req, 0);
        end

        // R6 re-check after each event
        configure(4, 4);
        base = src_idx;
        pulse_req(3); wait_cyc(60);
        for (int r = 0; r < 3; r++) begin
            check("R6 re-raise", host_dma_req, 1);
            ack();
            read_seq(4, base + 4 * r, "R4 order");
            wait_cyc(4);
        end
        check("R6 low at end", host_dma_req, 0);

        // R2 room gating, R8 queued fifth burst
        configure(16, 16);
        base = src_idx; p0 = pulls;
        pulse_req(5); wait_cyc(150);
        check("R2 burst held for room", pulls - p0, 64);
        check("R5 req full", host_dma_req, 1);
        ack();
        read_seq(16, base, "R4 order");
        wait_cyc(40);
        check("R2 R8 burst after room", pulls - p0, 80);
        read_seq(64, base + 16, "R4 order");

        // R7 empty read
        wait_cyc(3);
        host_read(d, uf);
        check("R7 empty data", d, 0);
        check("R7 underflow", uf, 1);

        // R1 bypass
        @(negedge clk); fifo_en = 0;
        @(negedge clk); sp_req = 1; #2;
        check("R1 req pass", host_dma_req, 1);
        @(negedge clk); sp_req = 0; #2;
        check("R1 req pass low", host_dma_req, 0);
        @(negedge clk); host_rd = 1; #2;
        check("R1 sp_rd pass", sp_rd, 1);
        check("R1 data pass", host_data, sp_data);
        @(negedge clk); host_rd = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule